// File: doc/BRIEF.md
# Multi-Source Reset Controller with Start-Up Timers

This block merges every reset request of a chip into one synchronous, active-low chip reset. The requests are power-on, a brown-out detect, an external reset pin, a watchdog timeout, a software reset strobe, and stack-full and stack-underflow errors. Supply and oscillator monitoring are analogue functions outside the block. Their results arrive as digital inputs.

A power-on or brown-out event restarts two cascaded start-up timers and holds the chip in reset until both have expired. The first timer counts pulses of a slow tick, nominally one every 32 µs. The second counts cycles of the main clock, which lets the oscillator settle. Every other source holds the chip in reset for a short fixed window and then releases it without touching the timers.

An 8-bit status register keeps sticky cause flags. The hardware clears a flag when its event fires, and software sets it back by writing a 1. After a reset, the flags that read 0 show what caused the most recent reset. The same register holds a software enable for brown-out detection.

Top module: `boot_reset_ctrl`

## Requirements
- R1: While `por_n` is low at a clock edge, the block resets synchronously. `chip_rst_n` goes to 0, `stat_rdata` becomes 8'hFC, and both timers clear. Tick pulses that arrive while `por_n` is low are not counted.
- R2: After power-on release or a brown-out event, `chip_rst_n` stays 0 until `PWRT_TICKS` pulses of `lf_tick` have been counted. It then stays 0 until `OST_CYCLES` further clock cycles have passed. It goes to 1 after edge `OST_CYCLES+1`, counted from the edge that sampled the last tick.
- R3: A watchdog, software or stack event sampled at an edge drives `chip_rst_n` to 0. `chip_rst_n` returns to 1 exactly `SHORT_CYCLES` (default 2) edges after the last edge on which the event was sampled. No tick is needed.
- R4: The external pin `ext_rst_n` is active low and is ignored while `ext_rst_en` is 0. When enabled, the pin drives `chip_rst_n` to 0 at the first edge at which it is low. `chip_rst_n` returns to 1 at the fourth edge after the pin rises: two edges of synchronizer and two edges of short window.
- R5: A brown-out event requires all three of `bor_detect`, `bor_en` and status bit 5 to be 1. If any one of them is 0, `bor_detect` has no effect on `chip_rst_n` or on the status register.
- R6: Each status bit is cleared by its own event:
  - bit 0 by a brown-out event;
  - bit 1 by power-on;
  - bit 2 by the pin while `low_power` is 1;
  - bit 3 by a watchdog timeout;
  - bit 4 by a software reset;
  - bit 6 by stack-full;
  - bit 7 by stack-underflow.

  A pin reset while `low_power` is 0 clears no bit. Bit 5 is the brown-out software enable and resets to 1.
- R7: A write (`stat_we` = 1) sets each flag bit whose `stat_wdata` bit is 1, and leaves flag bits written with 0 unchanged. Bit 5 takes the written value.
- R8: When an event and a write that targets the same flag bit fall in the same cycle, the flag ends up 0.
- R9: A watchdog, software, stack or pin event that occurs while the start-up timers are running neither restarts them nor shortens the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| por_n | input | 1 | Power-on request, active low, synchronous |
| lf_tick | input | 1 | One-cycle pulse of the slow time base |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| ext_rst_en | input | 1 | Enables the external reset pin |
| low_power | input | 1 | Chip is in a low-power mode |
| wdt_timeout | input | 1 | Watchdog timeout request |
| bor_detect | input | 1 | Supply below the brown-out threshold |
| bor_en | input | 1 | Hardware enable for brown-out reset |
| sw_reset | input | 1 | Software reset strobe |
| stack_full | input | 1 | Stack overflow reset request |
| stack_under | input | 1 | Stack underflow reset request |
| stat_we | input | 1 | Status register write enable |
| stat_wdata | input | 8 | Status register write data |
| stat_rdata | output | 8 | Status register contents |
| chip_rst_n | output | 1 | Synchronous chip reset, active low |

## Verification
The hardest state to reach from the ports is a short-window event, such as a watchdog timeout, that arrives while the start-up timers are still counting. The bench reaches it by raising a brown-out event and pulsing the watchdog between two slow ticks. It then measures the release edge against the tick count alone. Pin timing through the synchronizer and the race between an event and a write in the same cycle are reached in the same way. The bench drives the exact cycle and counts edges until release, sweeping every short source over several hold lengths.

// File: rtl/boot_rst_pkg.sv
// Shared constants and types of the reset controller.
// Assumes an 8-bit status register; the bit positions below fix the
// layout that software decodes.
package boot_rst_pkg;

    localparam int STATUS_W   = 8;
    localparam int FLAG_BROWN = 0;   // cleared by brown-out event
    localparam int FLAG_POWER = 1;   // cleared by power-on
    localparam int FLAG_SLEEP = 2;   // cleared by pin reset in low-power mode
    localparam int FLAG_WDOG  = 3;   // cleared by watchdog timeout
    localparam int FLAG_SWRST = 4;   // cleared by software reset strobe
    localparam int BIT_BOREN  = 5;   // software brown-out enable (not a flag)
    localparam int FLAG_STKF  = 6;   // cleared by stack full
    localparam int FLAG_STKU  = 7;   // cleared by stack underflow

    // Value loaded at power-on: power and brown-out flags cleared,
    // all other flags set, brown-out enable on.
    localparam logic [STATUS_W-1:0] STATUS_POR_VALUE = 8'hFC;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,   // waiting for start-up timers
        SEQ_SHORT = 2'd1,   // fixed short reset window
        SEQ_RUN   = 2'd2    // chip out of reset
    } seq_state_e;

endpackage

// File: rtl/stage_counter.sv
// One start-up timer stage: counts LIMIT enabled steps, then raises a
// sticky done until cleared.
// Assumes LIMIT >= 2; the step input is a one-cycle qualifier.
module stage_counter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic done
);
    localparam int          W    = $clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count qualified steps and latch completion.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (step && !done) begin
            if (cnt == LAST) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_clear_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !done);
    assert_done_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);
    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
endmodule

// File: rtl/pin_sync.sv
// Two-flop synchronizer for the external reset pin. The request
// asserts asynchronously as soon as the enabled pin goes low. It is
// released synchronously, two clock edges after the pin rises.
// Assumes the pin is active low and that pin_en changes only rarely.
module pin_sync (
    input  logic clk,
    input  logic pin_n,
    input  logic pin_en,
    output logic pin_req
);
    logic       gated_n;
    logic [1:0] stg;

    // Disabled pin reads as inactive.
    always_comb gated_n = pin_n | ~pin_en;

    // Shift in ones; clear at once when the pin asserts.
    always_ff @(posedge clk or negedge gated_n) begin
        if (!gated_n) begin
            stg <= 2'b00;
        end else begin
            stg <= {stg[0], 1'b1};
        end
    end

    // Request is active until the ones reach the last stage.
    always_comb pin_req = ~stg[1];
endmodule

// File: rtl/rst_flags.sv
// Status register. Flag bits are cleared by their events and set by
// software writes of 1; zeros written to flags are ignored. The
// brown-out enable bit follows writes directly.
// Assumes clr_evt is level-sensitive and that an event outranks a
// same-cycle write.
module rst_flags
    import boot_rst_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] clr_evt,
    input  logic                we,
    input  logic [STATUS_W-1:0] wdata,
    output logic [STATUS_W-1:0] status
);
    for (genvar i = 0; i < STATUS_W; i++) begin : g_bit
        if (i == BIT_BOREN) begin : g_enable
            // Software enable bit: write-through, a tied event forces it on.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status[i] <= STATUS_POR_VALUE[i];
                end else if (clr_evt[i]) begin
                    status[i] <= 1'b1;
                end else if (we) begin
                    status[i] <= wdata[i];
                end
            end

            assert_enable_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (we && !clr_evt[i]) |=> (status[i] == $past(wdata[i])));
        end else begin : g_flag
            // Sticky cause flag: event clears, software write of 1 sets.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    status[i] <= STATUS_POR_VALUE[i];
                end else if (clr_evt[i]) begin
                    status[i] <= 1'b0;
                end else if (we && wdata[i]) begin
                    status[i] <= 1'b1;
                end
            end

            assert_event_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
                clr_evt[i] |=> !status[i]);
            assert_write_one_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (we && wdata[i] && !clr_evt[i]) |=> status[i]);
            assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (!clr_evt[i] && !(we && wdata[i])) |=> $stable(status[i]));
        end
    end
endmodule

// File: rtl/rst_sequencer.sv
// Reset sequencer. A power event holds the chip until the start-up
// timers finish. A short event holds it for SHORT_CYCLES edges,
// unless a power hold is already in progress.
// Assumes timers_done drops at the edge after a power event.
module rst_sequencer
    import boot_rst_pkg::*;
#(
    parameter int SHORT_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_evt,
    input  logic short_evt,
    input  logic timers_done,
    output logic chip_rst_n
);
    localparam int           CW   = $clog2(SHORT_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(SHORT_CYCLES - 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    // State and short-window counter.
    always_ff @(posedge clk) begin
        if (!rst_n || power_evt) begin
            state <= SEQ_HOLD;
            cnt   <= '0;
        end else if (short_evt) begin
            if (state != SEQ_HOLD) begin
                state <= SEQ_SHORT;
            end
            cnt <= '0;
        end else begin
            case (state)
                SEQ_HOLD: begin
                    if (timers_done) begin
                        state <= SEQ_RUN;
                    end
                end
                SEQ_SHORT: begin
                    if (cnt == LAST) begin
                        state <= SEQ_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_RUN;
            endcase
        end
    end

    // Chip runs only in the run state.
    always_comb chip_rst_n = (state == SEQ_RUN);

    assert_power_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        power_evt |=> !chip_rst_n);
    assert_short_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        short_evt |=> !chip_rst_n);
    assert_hold_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_HOLD && !timers_done) |=> !chip_rst_n);
endmodule

// File: rtl/boot_reset_ctrl.sv
// Top of the reset controller. It merges the reset sources into one
// chip reset, sequences the two cascaded start-up timers, and keeps
// the status flags.
// Assumes all inputs except ext_rst_n are synchronous to clk, and
// that lf_tick is a one-cycle pulse.
module boot_reset_ctrl
    import boot_rst_pkg::*;
#(
    parameter int PWRT_TICKS   = 2048,
    parameter int OST_CYCLES   = 1024,
    parameter int SHORT_CYCLES = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                lf_tick,
    input  logic                ext_rst_n,
    input  logic                ext_rst_en,
    input  logic                low_power,
    input  logic                wdt_timeout,
    input  logic                bor_detect,
    input  logic                bor_en,
    input  logic                sw_reset,
    input  logic                stack_full,
    input  logic                stack_under,
    input  logic                stat_we,
    input  logic [STATUS_W-1:0] stat_wdata,
    output logic [STATUS_W-1:0] stat_rdata,
    output logic                chip_rst_n
);
    logic                pin_req;
    logic                bor_evt;
    logic                short_evt;
    logic                pwrt_done;
    logic                ost_done;
    logic [STATUS_W-1:0] clr_evt;

    pin_sync u_pin_sync (
        .clk     (clk),
        .pin_n   (ext_rst_n),
        .pin_en  (ext_rst_en),
        .pin_req (pin_req)
    );

    // Event decode: brown-out needs both enables, short events are merged.
    always_comb begin
        bor_evt   = bor_detect & bor_en & stat_rdata[BIT_BOREN];
        short_evt = wdt_timeout | sw_reset | stack_full | stack_under | pin_req;
    end

    // Map each event onto the flag it clears.
    always_comb begin
        clr_evt             = '0;
        clr_evt[FLAG_BROWN] = bor_evt;
        clr_evt[FLAG_SLEEP] = pin_req & low_power;
        clr_evt[FLAG_WDOG]  = wdt_timeout;
        clr_evt[FLAG_SWRST] = sw_reset;
        clr_evt[FLAG_STKF]  = stack_full;
        clr_evt[FLAG_STKU]  = stack_under;
    end

    stage_counter #(.LIMIT(PWRT_TICKS)) u_pwrt (
        .clk   (clk),
        .rst_n (por_n),
        .clear (bor_evt),
        .step  (lf_tick),
        .done  (pwrt_done)
    );

    stage_counter #(.LIMIT(OST_CYCLES)) u_ost (
        .clk   (clk),
        .rst_n (por_n),
        .clear (bor_evt),
        .step  (pwrt_done),
        .done  (ost_done)
    );

    rst_flags u_flags (
        .clk     (clk),
        .rst_n   (por_n),
        .clr_evt (clr_evt),
        .we      (stat_we),
        .wdata   (stat_wdata),
        .status  (stat_rdata)
    );

    rst_sequencer #(.SHORT_CYCLES(SHORT_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (por_n),
        .power_evt   (bor_evt),
        .short_evt   (short_evt),
        .timers_done (ost_done),
        .chip_rst_n  (chip_rst_n)
    );

    assert_ost_after_pwrt_R2: assert property (@(posedge clk) disable iff (!por_n)
        ost_done |-> pwrt_done);
    assert_bor_gated_R5: assert property (@(posedge clk) disable iff (!por_n)
        (bor_detect && !bor_en && !short_evt && chip_rst_n) |=> chip_rst_n);
endmodule

// File: tb/boot_reset_ctrl_bench.sv
module boot_reset_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 8;
    localparam int OS = 16;
    localparam int SH = 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       lf_tick = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       ext_rst_en = 1'b1;
    logic       low_power = 1'b0;
    logic       wdt_timeout = 1'b0;
    logic       bor_detect = 1'b0;
    logic       bor_en = 1'b1;
    logic       sw_reset = 1'b0;
    logic       stack_full = 1'b0;
    logic       stack_under = 1'b0;
    logic       stat_we = 1'b0;
    logic [7:0] stat_wdata = 8'h00;
    logic [7:0] stat_rdata;
    logic       chip_rst_n;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    boot_reset_ctrl #(.PWRT_TICKS(PW), .OST_CYCLES(OS), .SHORT_CYCLES(SH)) u_boot_reset_ctrl (
        .clk(clk), .por_n(por_n), .lf_tick(lf_tick), .ext_rst_n(ext_rst_n),
        .ext_rst_en(ext_rst_en), .low_power(low_power), .wdt_timeout(wdt_timeout),
        .bor_detect(bor_detect), .bor_en(bor_en), .sw_reset(sw_reset),
        .stack_full(stack_full), .stack_under(stack_under), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .chip_rst_n(chip_rst_n)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        stat_we = 1'b1; stat_wdata = d;
        @(negedge clk);
        stat_we = 1'b0; stat_wdata = 8'h00;
    endtask

    // Count edges until the chip leaves reset (called just after an edge).
    task automatic count_release(output int n);
        n = 0;
        while (chip_rst_n == 1'b0 && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Drive PW ticks and check the release edge (R2, optionally R9).
    task automatic power_up(input bit poke);
        int n;
        for (int t = 0; t < PW - 1; t++) begin
            lf_tick = 1'b1;
            @(negedge clk);
            lf_tick = 1'b0;
            if (poke && t == 1) begin
                wdt_timeout = 1'b1;
                @(negedge clk);
                wdt_timeout = 1'b0;
            end
            @(negedge clk);
        end
        repeat (3 * OS) @(negedge clk);
        check(chip_rst_n == 1'b0, "R2 held one tick short", int'(chip_rst_n), 0);
        lf_tick = 1'b1;
        @(negedge clk);
        lf_tick = 1'b0;
        count_release(n);
        check(n == OS + 1, poke ? "R9 release edge with watchdog during timers"
                                : "R2 release edge after last tick", n, OS + 1);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int bitpos;
        logic [7:0] expv;

        // R1: power-on state; ticks during reset are ignored
        @(negedge clk);
        lf_tick = 1'b1;
        repeat (3) @(negedge clk);
        lf_tick = 1'b0;
        check(chip_rst_n == 1'b0, "R1 chip reset during power-on", int'(chip_rst_n), 0);
        check(stat_rdata == 8'hFC, "R1 status reset value", stat_rdata, 8'hFC);
        por_n = 1'b1;
        @(negedge clk);
        power_up(1'b0);
        check(stat_rdata == 8'hFC, "R6 status after power-on", stat_rdata, 8'hFC);

        // R7: writing ones sets flags, zeros are ignored, bit 5 follows
        wr(8'hFF);
        check(stat_rdata == 8'hFF, "R7 write ones", stat_rdata, 8'hFF);
        wr(8'h00);
        check(stat_rdata == 8'hDF, "R7 write zeros", stat_rdata, 8'hDF);

        // R5: brown-out gated by the software bit
        bor_detect = 1'b1;
        @(negedge clk);
        bor_detect = 1'b0;
        @(negedge clk);
        check(chip_rst_n == 1'b1 && stat_rdata == 8'hDF, "R5 brown-out off by software bit",
              {chip_rst_n, stat_rdata}, 9'h1DF);
        wr(8'h20);
        check(stat_rdata == 8'hFF, "R7 restore enable", stat_rdata, 8'hFF);

        // R5: brown-out gated by the hardware enable
        bor_en = 1'b0;
        bor_detect = 1'b1;
        @(negedge clk);
        bor_detect = 1'b0;
        @(negedge clk);
        check(chip_rst_n == 1'b1 && stat_rdata == 8'hFF, "R5 brown-out off by hardware enable",
              {chip_rst_n, stat_rdata}, 9'h1FF);
        bor_en = 1'b1;

        // R3/R6: sweep short sources over hold lengths
        for (int src = 0; src < 4; src++) begin
            for (int hold = 1; hold <= 3; hold++) begin
                bitpos = (src == 0) ? 3 : (src == 1) ? 4 : (src == 2) ? 6 : 7;
                expv = 8'hFF & ~(8'h01 << bitpos);
                wdt_timeout = (src == 0); sw_reset = (src == 1);
                stack_full = (src == 2); stack_under = (src == 3);
                repeat (hold) @(negedge clk);
                wdt_timeout = 1'b0; sw_reset = 1'b0; stack_full = 1'b0; stack_under = 1'b0;
                check(chip_rst_n == 1'b0, "R3 short event asserts reset", int'(chip_rst_n), 0);
                count_release(n);
                check(n == SH, "R3 short window length", n, SH);
                check(stat_rdata == expv, "R6 short source flag", stat_rdata, expv);
                wr(8'hFF);
            end
        end

        // R8: event beats a same-cycle write
        wdt_timeout = 1'b1; stat_we = 1'b1; stat_wdata = 8'hFF;
        @(negedge clk);
        wdt_timeout = 1'b0; stat_we = 1'b0; stat_wdata = 8'h00;
        check(stat_rdata == 8'hF7, "R8 event wins over write", stat_rdata, 8'hF7);
        count_release(n);
        wr(8'hFF);

        // R4: disabled pin is ignored
        ext_rst_en = 1'b0; ext_rst_n = 1'b0;
        n = 0;
        repeat (6) begin
            @(negedge clk);
            if (chip_rst_n != 1'b1) n++;
        end
        check(n == 0 && stat_rdata == 8'hFF, "R4 disabled pin ignored", n, 0);
        ext_rst_n = 1'b1;
        @(negedge clk);
        ext_rst_en = 1'b1;
        repeat (3) @(negedge clk);

        // R4/R6: enabled pin, normal and low-power modes
        for (int lp = 0; lp < 2; lp++) begin
            for (int hold = 1; hold <= 3; hold++) begin
                low_power = lp[0];
                ext_rst_n = 1'b0;
                @(negedge clk);
                check(chip_rst_n == 1'b0, "R4 pin asserts at first edge", int'(chip_rst_n), 0);
                repeat (hold - 1) @(negedge clk);
                ext_rst_n = 1'b1;
                count_release(n);
                check(n == 4, "R4 pin release edge count", n, 4);
                expv = lp ? 8'hFB : 8'hFF;
                check(stat_rdata == expv, "R6 pin flag by mode", stat_rdata, expv);
                low_power = 1'b0;
                wr(8'hFF);
            end
        end

        // R5/R6/R9: enabled brown-out restarts timers; watchdog mid-wait
        bor_detect = 1'b1;
        @(negedge clk);
        bor_detect = 1'b0;
        check(chip_rst_n == 1'b0 && stat_rdata == 8'hFE, "R5 brown-out asserts and clears flag",
              {chip_rst_n, stat_rdata}, 9'h0FE);
        power_up(1'b1);
        check(stat_rdata == 8'hF6, "R6 flags after brown-out and watchdog", stat_rdata, 8'hF6);

        // R1: power-on again from running
        por_n = 1'b0;
        @(negedge clk);
        check(chip_rst_n == 1'b0 && stat_rdata == 8'hFC, "R1 power-on from run",
              {chip_rst_n, stat_rdata}, 9'h0FC);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule